// File: doc/BRIEF.md
# Tolerance-Based Run-Length Encoder

This block compresses a stream of fixed-width sensor samples into tokens. It takes one sample per accepted input cycle. Consecutive samples that belong together are merged into one run token, which holds a tag, a repeat count and a value. A sample that stands alone leaves as a literal token. In exact mode a run holds only identical samples. In tolerant mode a sample joins the open run when its distance from the run's first sample is no more than a programmable tolerance, so the output is lossy.

Three runtime settings bound each run: the count field width, the block length and the tolerance. The count field width caps how long a run can grow. The block length forces every run to close at a fixed sample interval, so that no run crosses a block edge. A flush pulse closes whatever run is still open. Both sides of the block use valid/ready handshakes. When the output stalls, the input stalls too, and no token is lost or repeated. In exact mode the token stream can be longer than the raw sample stream.

Top module: `rle_encoder`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: In exact mode (cfg_lossy=0), consecutive identical samples form one run. A run of two or more samples is emitted as out_tag=1, out_count=length, out_value=sample. A single sample is emitted as out_tag=0, out_count=1.
- R3: In tolerant mode (cfg_lossy=1), a sample joins the open run when the unsigned absolute difference between the sample and the run value is at most cfg_tol. The difference is computed without wrap-around. The run value is the run's first sample.
- R4: In exact mode, cfg_tol has no effect on the tokens produced.
- R5: A run never exceeds 2^w-1 samples, where w is cfg_code_w clamped to the range 1..CNT_W. The next sample after a full run starts a new run.
- R6: When cfg_blk_len is nonzero, the open run is closed after every cfg_blk_len accepted samples. The block position restarts after a flush. A cfg_blk_len of 0 disables block closing.
- R7: A flush pulse emits the open run as a token, and in_ready is 0 while flush is 1. A flush with no open run emits nothing.
- R8: While out_valid=1 and out_ready=0, the token is held stable and in_ready is 0. No token is dropped or duplicated under any output backpressure pattern.
- R9: When a run reaches the count cap on the same sample that ends a block, exactly one token is emitted for that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_lossy | input | 1 | 1 selects tolerant mode, 0 selects exact mode |
| cfg_tol | input | DATA_W | Tolerance used in tolerant mode |
| cfg_code_w | input | CW_W | Count field width, clamped to 1..CNT_W |
| cfg_blk_len | input | BLK_W | Samples per block, 0 disables blocks |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Encoder accepts a sample this cycle |
| in_data | input | DATA_W | Input sample |
| flush | input | 1 | Close the open run |
| out_valid | output | 1 | Token valid |
| out_ready | input | 1 | Downstream accepts the token |
| out_tag | output | 1 | 1 = run token, 0 = literal |
| out_count | output | CNT_W | Run length (1 for a literal) |
| out_value | output | DATA_W | Run value or literal sample |

## Verification
Two events can land on the same sample: the run reaching its count cap, and the block reaching its end. A 2-bit count width combined with a 3-sample block provokes this case with a stream of identical samples. Each closing must then produce exactly one count-3 token, with no extra or empty token after it. Flush arriving while the output is stalled is a second overlap. Random output backpressure provokes it, and the bench judges the result by comparing the full token list against the expected list.

// File: rtl/rle_pkg.sv
package rle_pkg;

    typedef enum logic {
        TOK_LITERAL = 1'b0,
        TOK_RUN     = 1'b1
    } tok_kind_e;

endpackage

// File: rtl/rle_tol_cmp.sv
module rle_tol_cmp #(
    parameter int DATA_W = 8
) (
    input  logic              lossy,
    input  logic [DATA_W-1:0] tol,
    input  logic [DATA_W-1:0] sample,
    input  logic [DATA_W-1:0] ref_val,
    output logic              hit
);
    logic [DATA_W:0] diff;

    always_comb begin
        if (sample >= ref_val) diff = {1'b0, sample} - {1'b0, ref_val};
        else                   diff = {1'b0, ref_val} - {1'b0, sample};
        hit = lossy ? (diff <= {1'b0, tol}) : (sample == ref_val);
    end
endmodule

// File: rtl/rle_block_ctr.sv
module rle_block_ctr #(
    parameter int BLK_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             clear,
    input  logic [BLK_W-1:0] blk_len,
    output logic             last
);
    logic [BLK_W-1:0] pos_d, pos_q;

    always_comb begin
        last  = (blk_len != '0) && (({1'b0, pos_q} + 1'b1) == {1'b0, blk_len});
        pos_d = pos_q;
        if (clear)     pos_d = '0;
        else if (step) pos_d = last ? '0 : pos_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end
endmodule

// File: rtl/rle_encoder.sv
module rle_encoder #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8,
    parameter int BLK_W  = 8,
    localparam int CW_W  = $clog2(CNT_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_lossy,
    input  logic [DATA_W-1:0] cfg_tol,
    input  logic [CW_W-1:0]   cfg_code_w,
    input  logic [BLK_W-1:0]  cfg_blk_len,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              flush,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_tag,
    output logic [CNT_W-1:0]  out_count,
    output logic [DATA_W-1:0] out_value
);
    import rle_pkg::*;

    typedef struct packed {
        logic              active;
        logic [DATA_W-1:0] run_val;
        logic [CNT_W-1:0]  run_len;
        logic              close_pend;
        logic              ov;
        tok_kind_e         otag;
        logic [CNT_W-1:0]  ocnt;
        logic [DATA_W-1:0] oval;
    } st_t;

    localparam st_t ST_RST = '{
        active: 1'b0, run_val: '0, run_len: '0, close_pend: 1'b0,
        ov: 1'b0, otag: TOK_LITERAL, ocnt: '0, oval: '0
    };

    st_t st_d, st_q;

    logic             hit;
    logic             blk_last;
    logic             accept;
    logic             slot_free;
    logic             close_req;
    logic             joinable;
    logic [CW_W-1:0]  cw_eff;
    logic [CNT_W:0]   cap_wide;
    logic [CNT_W-1:0] cap;

    rle_tol_cmp #(.DATA_W(DATA_W)) u_cmp (
        .lossy   (cfg_lossy),
        .tol     (cfg_tol),
        .sample  (in_data),
        .ref_val (st_q.run_val),
        .hit     (hit)
    );

    rle_block_ctr #(.BLK_W(BLK_W)) u_blk (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (accept),
        .clear   (flush),
        .blk_len (cfg_blk_len),
        .last    (blk_last)
    );

    always_comb begin
        if (cfg_code_w == '0)                    cw_eff = CW_W'(1);
        else if (cfg_code_w > CW_W'(CNT_W))      cw_eff = CW_W'(CNT_W);
        else                                     cw_eff = cfg_code_w;
        cap_wide = ((CNT_W+1)'(1) << cw_eff) - 1'b1;
        cap      = cap_wide[CNT_W-1:0];
    end

    always_comb begin
        st_d      = st_q;
        slot_free = !st_q.ov || out_ready;
        in_ready  = slot_free && !st_q.close_pend && !flush;
        accept    = in_valid && in_ready;
        close_req = st_q.active && (st_q.close_pend || flush);
        joinable  = st_q.active && hit && (st_q.run_len < cap);

        if (st_q.ov && out_ready) st_d.ov = 1'b0;

        if (close_req) begin
            if (slot_free) begin
                st_d.ov         = 1'b1;
                st_d.otag       = (st_q.run_len > 1) ? TOK_RUN : TOK_LITERAL;
                st_d.ocnt       = st_q.run_len;
                st_d.oval       = st_q.run_val;
                st_d.active     = 1'b0;
                st_d.close_pend = 1'b0;
            end else begin
                st_d.close_pend = 1'b1;
            end
        end else if (accept) begin
            if (joinable) begin
                st_d.run_len = st_q.run_len + 1'b1;
            end else begin
                if (st_q.active) begin
                    st_d.ov   = 1'b1;
                    st_d.otag = (st_q.run_len > 1) ? TOK_RUN : TOK_LITERAL;
                    st_d.ocnt = st_q.run_len;
                    st_d.oval = st_q.run_val;
                end
                st_d.active  = 1'b1;
                st_d.run_val = in_data;
                st_d.run_len = CNT_W'(1);
            end
            if (blk_last) st_d.close_pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RST;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.ov;
    assign out_tag   = st_q.otag;
    assign out_count = st_q.ocnt;
    assign out_value = st_q.oval;
endmodule

// File: rtl/rle_encoder_chk.sv
module rle_encoder_chk #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8,
    parameter int CW_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CW_W-1:0]   cfg_code_w,
    input logic              in_ready,
    input logic              flush,
    input logic              out_valid,
    input logic              out_ready,
    input logic              out_tag,
    input logic [CNT_W-1:0]  out_count,
    input logic [DATA_W-1:0] out_value
);
    logic [CW_W-1:0] w_chk;
    logic [CNT_W:0]  lim_chk;

    always_comb begin
        w_chk = cfg_code_w;
        if (w_chk == '0) w_chk = CW_W'(1);
        if (w_chk > CW_W'(CNT_W)) w_chk = CW_W'(CNT_W);
        lim_chk = ((CNT_W+1)'(1) << w_chk) - 1'b1;
    end

    AST_HOLD_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_tag) && $stable(out_count) && $stable(out_value)); // R8
    AST_STALL_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready); // R8
    AST_FLUSH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !in_ready); // R7
    AST_LITERAL_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_tag |-> out_count == CNT_W'(1)); // R2
    AST_RUN_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_tag |-> out_count >= CNT_W'(2)); // R2
    AST_COUNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> {1'b0, out_count} <= lim_chk); // R5
endmodule

bind rle_encoder rle_encoder_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W), .CW_W(CW_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_code_w (cfg_code_w),
    .in_ready   (in_ready),
    .flush      (flush),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_tag    (out_tag),
    .out_count  (out_count),
    .out_value  (out_value)
);

// File: tb/rle_encoder_bench.sv
module rle_encoder_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_lossy = 1'b0;
    logic [7:0] cfg_tol = '0;
    logic [3:0] cfg_code_w = 4'd8;
    logic [7:0] cfg_blk_len = '0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = '0;
    logic       flush = 1'b0;
    logic       out_valid;
    logic       out_ready;
    logic       out_tag;
    logic [7:0] out_count;
    logic [7:0] out_value;
    logic       bp_en = 1'b0;
    logic [7:0] lfsr;

    int checks = 0;
    int fails  = 0;
    int ncap   = 0;
    logic [16:0] capt [16];

    always #2 clk = ~clk;

    rle_encoder u_rle_encoder (
        .clk(clk), .rst_n(rst_n), .cfg_lossy(cfg_lossy), .cfg_tol(cfg_tol),
        .cfg_code_w(cfg_code_w), .cfg_blk_len(cfg_blk_len), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .flush(flush), .out_valid(out_valid),
        .out_ready(out_ready), .out_tag(out_tag), .out_count(out_count), .out_value(out_value)
    );

    always @(posedge clk or negedge rst_n)
        if (!rst_n) lfsr <= 8'h5A;
        else        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    assign out_ready = !bp_en || lfsr[0];

    always @(negedge clk)
        if (rst_n && out_valid && out_ready) begin
            if (ncap < 16) capt[ncap] = {out_tag, out_count, out_value};
            ncap++;
        end

    typedef struct packed {
        logic             lossy;
        logic [7:0]       tol;
        logic [3:0]       cw;
        logic [7:0]       blk;
        logic             bp;
        int               ns;
        logic [0:7][7:0]  smp;
        int               nt;
        logic [0:4][16:0] tok;
    } vec_t;

    // token = {tag, count, value}
    localparam vec_t VT [9] = '{
        // R2: exact mode merges equal samples
        '{1'b0, 8'd0, 4'd8, 8'd0, 1'b0, 8, '{8'd0,8'd0,8'd0,8'd1,8'd3,8'd5,8'd5,8'd6}, 5,
          '{{1'b1,8'd3,8'd0},{1'b0,8'd1,8'd1},{1'b0,8'd1,8'd3},{1'b1,8'd2,8'd5},{1'b0,8'd1,8'd6}}},
        // R3: tolerant mode, tolerance 1
        '{1'b1, 8'd1, 4'd8, 8'd0, 1'b0, 8, '{8'd0,8'd0,8'd0,8'd1,8'd3,8'd5,8'd5,8'd6}, 3,
          '{{1'b1,8'd4,8'd0},{1'b0,8'd1,8'd3},{1'b1,8'd3,8'd5},17'h0,17'h0}},
        // R4: tolerance ignored in exact mode
        '{1'b0, 8'd5, 4'd8, 8'd0, 1'b0, 3, '{8'd0,8'd1,8'd0,8'd0,8'd0,8'd0,8'd0,8'd0}, 3,
          '{{1'b0,8'd1,8'd0},{1'b0,8'd1,8'd1},{1'b0,8'd1,8'd0},17'h0,17'h0}},
        // R3: no wrap-around in the distance
        '{1'b1, 8'd3, 4'd8, 8'd0, 1'b0, 2, '{8'd254,8'd1,8'd0,8'd0,8'd0,8'd0,8'd0,8'd0}, 2,
          '{{1'b0,8'd1,8'd254},{1'b0,8'd1,8'd1},17'h0,17'h0,17'h0}},
        // R5: 2-bit count caps runs at 3
        '{1'b0, 8'd0, 4'd2, 8'd0, 1'b0, 5, '{8'd7,8'd7,8'd7,8'd7,8'd7,8'd0,8'd0,8'd0}, 2,
          '{{1'b1,8'd3,8'd7},{1'b1,8'd2,8'd7},17'h0,17'h0,17'h0}},
        // R6: block of 4 closes the run
        '{1'b0, 8'd0, 4'd8, 8'd4, 1'b0, 6, '{8'd9,8'd9,8'd9,8'd9,8'd9,8'd9,8'd0,8'd0}, 2,
          '{{1'b1,8'd4,8'd9},{1'b1,8'd2,8'd9},17'h0,17'h0,17'h0}},
        // R9: cap and block end on the same sample
        '{1'b0, 8'd0, 4'd2, 8'd3, 1'b0, 6, '{8'd4,8'd4,8'd4,8'd4,8'd4,8'd4,8'd0,8'd0}, 2,
          '{{1'b1,8'd3,8'd4},{1'b1,8'd3,8'd4},17'h0,17'h0,17'h0}},
        // R8: tolerant mode under backpressure
        '{1'b1, 8'd2, 4'd8, 8'd0, 1'b1, 6, '{8'd10,8'd11,8'd12,8'd13,8'd9,8'd9,8'd0,8'd0}, 3,
          '{{1'b1,8'd3,8'd10},{1'b0,8'd1,8'd13},{1'b1,8'd2,8'd9},17'h0,17'h0}},
        // R8: exact mode under backpressure
        '{1'b0, 8'd0, 4'd8, 8'd0, 1'b1, 8, '{8'd0,8'd0,8'd0,8'd1,8'd3,8'd5,8'd5,8'd6}, 5,
          '{{1'b1,8'd3,8'd0},{1'b0,8'd1,8'd1},{1'b0,8'd1,8'd3},{1'b1,8'd2,8'd5},{1'b0,8'd1,8'd6}}}
    };
    localparam string VREQ [9] = '{"R2", "R3", "R4", "R3", "R5", "R6", "R9", "R8", "R8"};

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] s);
        in_valid = 1'b1;
        in_data  = s;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic pulse_flush();
        flush = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b0, "R7", "in_ready during flush", int'(in_ready), 0);
        @(posedge clk);
        #1 flush = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
        @(posedge clk);
        #1;

        for (int v = 0; v < 9; v++) begin
            cfg_lossy   = VT[v].lossy;
            cfg_tol     = VT[v].tol;
            cfg_code_w  = VT[v].cw;
            cfg_blk_len = VT[v].blk;
            bp_en       = VT[v].bp;
            ncap        = 0;
            for (int i = 0; i < VT[v].ns; i++) send(VT[v].smp[i]);
            pulse_flush();
            repeat (40) @(posedge clk);
            #1 bp_en = 1'b0;
            repeat (4) @(posedge clk);
            #1;
            check(ncap == VT[v].nt, VREQ[v], $sformatf("token count vec %0d", v), ncap, VT[v].nt);
            for (int t = 0; t < VT[v].nt; t++)
                if (t < ncap)
                    check(capt[t] == VT[v].tok[t], VREQ[v], $sformatf("vec %0d token %0d", v, t),
                          int'(capt[t]), int'(VT[v].tok[t]));
        end

        // R7: flush with nothing open produces no token
        ncap = 0;
        pulse_flush();
        repeat (5) @(posedge clk);
        #1;
        check(ncap == 0, "R7", "empty flush tokens", ncap, 0);

        // R6: block length 0 never closes a run on its own
        cfg_lossy = 1'b0; cfg_code_w = 4'd8; cfg_blk_len = 8'd0; ncap = 0;
        for (int i = 0; i < 10; i++) send(8'd33);
        repeat (5) @(posedge clk);
        #1;
        check(ncap == 0, "R6", "no token before flush", ncap, 0);
        pulse_flush();
        repeat (5) @(posedge clk);
        #1;
        check(ncap == 1 && capt[0] == {1'b1, 8'd10, 8'd33}, "R6", "unbounded run token",
              int'(capt[0]), int'({1'b1, 8'd10, 8'd33}));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule